// File: doc/BRIEF.md
# Memory-Mapped Quad-SPI Flash Read Engine

This block places two serial NOR flash devices of 16 MiB each side by side in one 32 MiB read-only address window. A host issues a read of one 32-bit word through a valid/ready request port. The engine then runs a complete quad I/O fast-read transaction on the flash pins and returns the assembled word on a one-cycle response strobe.

Each transaction has a fixed order. First comes the command byte, sent one bit per serial clock on the lowest data line. Next come the 24-bit device address and a continuous-read mode byte, both on all four lines. A stretch of dummy clocks follows with the bus released. Last, eight nibbles are received and packed into a little-endian word.

Two settings come from outside the block: an enable bit and a three-bit divider exponent that sets the serial clock rate. Dropping the enable ends any transfer in progress and deselects both devices. A request made while the engine is disabled is refused at once with an error flag.

Top module: `qspi_xip_reader`

## Requirements
- R1: Every transfer begins with the command byte 0xEB. It is sent most significant bit first on `qspi_io_out[0]`, one bit per serial clock, for 8 serial clocks with `qspi_io_oe` = 4'b0001.
- R2: After the command, `req_addr[23:0]` goes out as 6 nibbles, most significant nibble first, on `qspi_io_out[3:0]`. The mode byte 0xFF follows as 2 nibbles. During these 8 serial clocks `qspi_io_oe` = 4'b1111.
- R3: After the mode byte come 4 dummy serial clocks (two bytes of quad clocking) and then 8 data serial clocks, 28 serial clocks in all per transfer. `qspi_io_oe` = 4'b0000 throughout the dummy and data clocks.
- R4: `qspi_io_in` is sampled as the serial clock rises during the data clocks, high nibble of each byte first. The first byte received lands in `rsp_data[7:0]` and the fourth in `rsp_data[31:24]`.
- R5: `req_addr[24]` = 0 drives `qspi_cs_n[0]` low and `req_addr[24]` = 1 drives `qspi_cs_n[1]` low. At most one chip select is ever low.
- R6: The serial clock period is 2^(d+1) reference clocks, where d is `cfg_div`, latched when a request is accepted. Values below 2 are treated as 2, so the largest setting of 7 gives 256 clocks.
- R7: The serial clock idles low and is low whenever both chip selects are high. After reset both chip selects are high, `req_ready` is 1 and `rsp_valid` is 0.
- R8: Between two transfers both chip selects stay high for at least one full serial clock period.
- R9: A request accepted while `cfg_enable` is 0 gets `rsp_valid` on the next clock with `rsp_err` = 1 and `rsp_data` = 0, and no chip select goes low.
- R10: If `cfg_enable` falls during a transfer, both chip selects are high on the next clock. That transfer is answered with `rsp_err` = 1 and `rsp_data` = 0.
- R11: `req_ready` is 1 only while the engine is idle, so it is 0 on the clock after a request that starts a transfer. `rsp_valid` is a single-cycle pulse, and a good transfer answers with `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_div | input | 3 | Serial clock divider exponent |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | 25 | Byte address in the 32 MiB window |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Read word |
| rsp_err | output | 1 | Request refused or aborted |
| qspi_sck | output | 1 | Serial clock to both devices |
| qspi_cs_n | output | 2 | Active-low chip selects |
| qspi_io_out | output | 4 | Data lines driven toward the devices |
| qspi_io_oe | output | 4 | Per-line output enables |
| qspi_io_in | input | 4 | Data lines read from the devices |

## Verification
A behavioural flash model records the command, address and mode bits and the enable pattern at every rising serial clock. It then drives a distinct byte pattern back during the data clocks. Reads to both devices, with different address patterns and different data bytes, show whether chip select decoding, nibble order and byte order are each right. Divider settings below, at and above the legal range tell the clamp apart from plain division. Back-to-back reads expose a missing deselect gap, and a disabled request and a mid-transfer disable separate the refusal path from the abort path.

// File: rtl/qspi_xip_pkg.sv
package qspi_xip_pkg;

   localparam logic [7:0] RD_OPCODE = 8'hEB;
   localparam logic [7:0] RD_MODE   = 8'hFF;
   localparam int         CMD_CYCLES  = 8;
   localparam int         MODE_CYCLES = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } eng_state_t;

   function automatic int xfer_cycles(input int addr_bits, input int dummy, input int data_w);
      return CMD_CYCLES + addr_bits / 4 + MODE_CYCLES + dummy + data_w / 4;
   endfunction

endpackage

// File: rtl/qspi_sck_gen.sv
module qspi_sck_gen #(
   parameter int DIV_W   = 3,
   parameter int DIV_MIN = 2,
   parameter int DIV_MAX = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sync,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);
   localparam int CNT_W = DIV_MAX + 1;

   initial begin
      if (DIV_MIN < 2)              $error("divider minimum must be at least 2");
      if (DIV_MAX >= (1 << DIV_W))  $error("divider field too narrow");
      if (DIV_MAX < DIV_MIN)        $error("divider range empty");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_clamped;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;

   always_comb begin
      if (div_in < DIV_W'(DIV_MIN))      div_clamped = DIV_W'(DIV_MIN);
      else if (div_in > DIV_W'(DIV_MAX)) div_clamped = DIV_W'(DIV_MAX);
      else                               div_clamped = div_in;
   end

   assign half_m1 = (CNT_W'(1) << div_q) - CNT_W'(1);
   assign tick    = run && !sync && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(DIV_MIN);
         cnt_q <= '0;
      end else begin
         if (load) div_q <= div_clamped;
         if (!run || sync || tick) cnt_q <= '0;
         else                      cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> $stable(div_q)); // R6

endmodule

// File: rtl/qspi_io_drive.sv
module qspi_io_drive
   import qspi_xip_pkg::*;
#(
   parameter int ADDR_BITS = 24,
   parameter int DUMMY_CYC = 4,
   parameter int DATA_W    = 32,
   parameter int CYC_W     = 5
) (
   input  logic                 active,
   input  logic [CYC_W-1:0]     cyc,
   input  logic [ADDR_BITS-1:0] addr,
   output logic [3:0]           io_out,
   output logic [3:0]           io_oe,
   output logic                 data_ph,
   output logic                 last_cyc
);
   localparam int TOTAL = xfer_cycles(ADDR_BITS, DUMMY_CYC, DATA_W);
   localparam logic [CYC_W-1:0] CMD_END   = CYC_W'(CMD_CYCLES);
   localparam logic [CYC_W-1:0] ADDR_END  = CYC_W'(CMD_CYCLES + ADDR_BITS / 4);
   localparam logic [CYC_W-1:0] MODE_END  = CYC_W'(CMD_CYCLES + ADDR_BITS / 4 + MODE_CYCLES);
   localparam logic [CYC_W-1:0] DUMMY_END = CYC_W'(CMD_CYCLES + ADDR_BITS / 4 + MODE_CYCLES + DUMMY_CYC);
   localparam logic [CYC_W-1:0] LAST      = CYC_W'(TOTAL - 1);

   initial begin
      if (ADDR_BITS % 4 != 0)  $error("address width must be whole nibbles");
      if (TOTAL >= (1 << CYC_W)) $error("cycle counter too narrow");
   end

   logic [CYC_W-1:0]     idx;
   logic [ADDR_BITS-1:0] addr_sh;
   logic [7:0]           op_sh;

   assign idx     = cyc - CMD_END;
   assign addr_sh = addr << {idx, 2'b00};
   assign op_sh   = RD_OPCODE << cyc[2:0];

   always_comb begin
      io_out   = '0;
      io_oe    = '0;
      data_ph  = 1'b0;
      last_cyc = (cyc == LAST);
      if (!active) begin
         last_cyc = 1'b0;
      end else if (cyc < CMD_END) begin
         io_oe     = 4'b0001;
         io_out[0] = op_sh[7];
      end else if (cyc < ADDR_END) begin
         io_oe  = 4'b1111;
         io_out = addr_sh[ADDR_BITS-1 -: 4];
      end else if (cyc < MODE_END) begin
         io_oe  = 4'b1111;
         io_out = (cyc == ADDR_END) ? RD_MODE[7:4] : RD_MODE[3:0];
      end else if (cyc < DUMMY_END) begin
         io_oe  = 4'b0000;
      end else begin
         data_ph = 1'b1;
      end
   end

endmodule

// File: rtl/qspi_word_pack.sv
module qspi_word_pack #(
   parameter int DATA_W    = 32,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap,
   input  logic [3:0]        nib,
   output logic [DATA_W-1:0] word
);
   localparam int NIBS  = DATA_W / 4;
   localparam int CNT_W = $clog2(NIBS);

   initial begin
      if (DATA_W % 8 != 0 || DATA_W < 16) $error("word must be whole bytes, two or more");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (cap)    cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         logic [CNT_W-1:0] pos;
         assign pos = {cnt_q[CNT_W-1:1], ~cnt_q[0]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word <= '0;
            else if (clr)  word <= '0;
            else if (cap)  word[{pos, 2'b00} +: 4] <= nib;
         end
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word <= '0;
            else if (clr)  word <= '0;
            else if (cap)  word <= {word[DATA_W-5:0], nib};
         end
      end
   endgenerate

endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader
   import qspi_xip_pkg::*;
#(
   parameter int DEV_ADDR_W = 24,
   parameter int NUM_DEV    = 2,
   parameter int DATA_W     = 32,
   parameter int DIV_W      = 3,
   parameter int DIV_MIN    = 2,
   parameter int DIV_MAX    = 7,
   parameter int DUMMY_CYC  = 4,
   parameter bit LSB_FIRST  = 1'b1,
   localparam int SEL_W     = $clog2(NUM_DEV),
   localparam int ADDR_W    = DEV_ADDR_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              qspi_sck,
   output logic [NUM_DEV-1:0] qspi_cs_n,
   output logic [3:0]        qspi_io_out,
   output logic [3:0]        qspi_io_oe,
   input  logic [3:0]        qspi_io_in
);
   localparam int TOTAL   = xfer_cycles(DEV_ADDR_W, DUMMY_CYC, DATA_W);
   localparam int CYC_W   = $clog2(TOTAL + 1);
   localparam int MIN_GAP = 2 << DIV_MIN;
   localparam int GAP_W   = $clog2(MIN_GAP + 1);

   initial begin
      if (NUM_DEV < 2 || (NUM_DEV & (NUM_DEV - 1)) != 0) $error("device count must be a power of two");
   end

   eng_state_t                state_q;
   logic [CYC_W-1:0]          cyc_q;
   logic                      sck_q;
   logic                      gap_q;
   logic [DEV_ADDR_W-1:0]     addr_q;
   logic [NUM_DEV-1:0]        cs_n_q;
   logic                      tick, data_ph, last_cyc;
   logic                      accept, start, abort, cap, sync;
   logic [DATA_W-1:0]         pack_word;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign start     = accept && cfg_enable;
   assign abort     = (state_q == ST_XFER) && !cfg_enable;
   assign sync      = abort;
   assign cap       = (state_q == ST_XFER) && cfg_enable && tick && !sck_q && data_ph;

   qspi_sck_gen #(
      .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
   ) u_sck (
      .clk(clk), .rst_n(rst_n),
      .run(state_q != ST_IDLE), .sync(sync),
      .load(start), .div_in(cfg_div),
      .tick(tick)
   );

   qspi_io_drive #(
      .ADDR_BITS(DEV_ADDR_W), .DUMMY_CYC(DUMMY_CYC), .DATA_W(DATA_W), .CYC_W(CYC_W)
   ) u_drive (
      .active(state_q == ST_XFER), .cyc(cyc_q), .addr(addr_q),
      .io_out(qspi_io_out), .io_oe(qspi_io_oe),
      .data_ph(data_ph), .last_cyc(last_cyc)
   );

   qspi_word_pack #(
      .DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)
   ) u_pack (
      .clk(clk), .rst_n(rst_n),
      .clr(start), .cap(cap), .nib(qspi_io_in),
      .word(pack_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cyc_q     <= '0;
         sck_q     <= 1'b0;
         gap_q     <= 1'b0;
         addr_q    <= '0;
         cs_n_q    <= '1;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (cfg_enable) begin
                     state_q <= ST_XFER;
                     cyc_q   <= '0;
                     sck_q   <= 1'b0;
                     addr_q  <= req_addr[DEV_ADDR_W-1:0];
                     cs_n_q  <= ~(NUM_DEV'(1) << req_addr[ADDR_W-1 -: SEL_W]);
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_data  <= '0;
                  end
               end
            end
            ST_XFER: begin
               if (abort) begin
                  state_q   <= ST_GAP;
                  gap_q     <= 1'b0;
                  sck_q     <= 1'b0;
                  cs_n_q    <= '1;
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_data  <= '0;
               end else if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                  end else begin
                     sck_q <= 1'b0;
                     if (last_cyc) begin
                        state_q   <= ST_GAP;
                        gap_q     <= 1'b0;
                        cs_n_q    <= '1;
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_data  <= pack_word;
                     end else begin
                        cyc_q <= cyc_q + CYC_W'(1);
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_q) state_q <= ST_IDLE;
                  gap_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign qspi_sck  = sck_q;
   assign qspi_cs_n = cs_n_q;

   logic [GAP_W-1:0] hi_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hi_cnt_q <= GAP_W'(MIN_GAP);
      else if (!(&qspi_cs_n))          hi_cnt_q <= '0;
      else if (hi_cnt_q != GAP_W'(MIN_GAP)) hi_cnt_q <= hi_cnt_q + GAP_W'(1);
   end

   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~qspi_cs_n)); // R5
   AST_CS_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (&qspi_cs_n)); // R10
   AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (&qspi_cs_n) |-> !qspi_sck); // R7
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '0)); // R9
   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((&qspi_cs_n) && !(&cs_n_next_w())) |-> (hi_cnt_q == GAP_W'(MIN_GAP))); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !req_ready); // R11

   function automatic logic [NUM_DEV-1:0] cs_n_next_w();
      return (state_q == ST_IDLE && start) ? ~(NUM_DEV'(1) << req_addr[ADDR_W-1 -: SEL_W]) : cs_n_q;
   endfunction

endmodule

// File: tb/tb_qspi_xip_reader.sv
module tb_qspi_xip_reader;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [2:0]  cfg_div = 3'd2;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [24:0] req_addr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_err;
   logic        qspi_sck;
   logic [1:0]  qspi_cs_n;
   logic [3:0]  qspi_io_out, qspi_io_oe;
   logic [3:0]  qspi_io_in = '0;

   int total = 0;
   int bad   = 0;
   int cyc_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qspi_xip_reader dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_enable(cfg_enable), .cfg_div(cfg_div),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .qspi_sck(qspi_sck), .qspi_cs_n(qspi_cs_n),
      .qspi_io_out(qspi_io_out), .qspi_io_oe(qspi_io_oe), .qspi_io_in(qspi_io_in)
   );

   // flash model state
   int          rise_k = 0;
   logic [7:0]  op_sr = '0;
   logic [23:0] addr_sr = '0;
   logic [7:0]  mode_sr = '0;
   int          oe_bad = 0;
   logic [1:0]  sel_seen = '0;
   int          prev_rise = 0;
   int          last_delta = 0;
   logic [7:0]  mdl_bytes [4];
   int          hi_run = 0;
   int          last_gap = 0;

   always @(posedge clk) begin
      cyc_cnt = cyc_cnt + 1;
      if (&qspi_cs_n) hi_run = hi_run + 1;
      else begin
         if (hi_run > 0) last_gap = hi_run;
         hi_run = 0;
      end
      if (cyc_cnt == WATCHDOG) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc_cnt, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   always @(posedge qspi_sck) begin
      if (rise_k < 8) begin
         op_sr = {op_sr[6:0], qspi_io_out[0]};
         if (qspi_io_oe != 4'b0001) oe_bad = oe_bad + 1;
      end else if (rise_k < 14) begin
         addr_sr = {addr_sr[19:0], qspi_io_out};
         if (qspi_io_oe != 4'b1111) oe_bad = oe_bad + 1;
      end else if (rise_k < 16) begin
         mode_sr = {mode_sr[3:0], qspi_io_out};
         if (qspi_io_oe != 4'b1111) oe_bad = oe_bad + 1;
      end else begin
         if (qspi_io_oe != 4'b0000) oe_bad = oe_bad + 1;
      end
      if (rise_k >= 1) last_delta = cyc_cnt - prev_rise;
      prev_rise = cyc_cnt;
      sel_seen = sel_seen | ~qspi_cs_n;
      rise_k = rise_k + 1;
   end

   always @(negedge qspi_sck) begin
      int j;
      j = rise_k - 20;
      if (j >= 0 && j < 8)
         qspi_io_in = j[0] ? mdl_bytes[j >> 1][3:0] : mdl_bytes[j >> 1][7:4];
   end

   task automatic check(input string req, input string what, input longint act, input longint exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      rise_k = 0; op_sr = '0; addr_sr = '0; mode_sr = '0;
      oe_bad = 0; sel_seen = '0; last_delta = 0;
   endtask

   task automatic issue(input logic [24:0] a);
      @(negedge clk);
      req_addr = a;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(output int seen);
      seen = 0;
      for (int i = 0; i < 20000; i++) begin
         if (rsp_valid) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic do_read(input logic [24:0] a, input logic [2:0] div, input int exp_period,
                          input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3);
      int seen;
      model_clear();
      mdl_bytes[0] = b0; mdl_bytes[1] = b1; mdl_bytes[2] = b2; mdl_bytes[3] = b3;
      cfg_div = div;
      issue(a);
      check("R11", "ready low while busy", req_ready, 0);
      wait_rsp(seen);
      check("R11", "response seen", seen, 1);
      check("R11", "no error", rsp_err, 0);
      check("R4", "read word", rsp_data, {b3, b2, b1, b0});
      check("R1", "opcode", op_sr, 8'hEB);
      check("R2", "address", addr_sr, a[23:0]);
      check("R2", "mode byte", mode_sr, 8'hFF);
      check("R3", "output enable errors", oe_bad, 0);
      check("R3", "serial clocks per transfer", rise_k, 28);
      check("R5", "device selected", sel_seen, a[24] ? 2'b10 : 2'b01);
      check("R6", "serial clock period", last_delta, exp_period);
      @(negedge clk);
      check("R11", "response pulse ends", rsp_valid, 0);
      check("R7", "chip selects released", qspi_cs_n, 2'b11);
      check("R7", "sck low when deselected", qspi_sck, 0);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R7", "reset chip selects", qspi_cs_n, 2'b11);
      check("R7", "reset sck", qspi_sck, 0);
      check("R7", "reset ready", req_ready, 1);
      check("R7", "reset rsp_valid", rsp_valid, 0);
   endtask

   task automatic t_back_to_back();
      model_clear();
      cfg_div = 3'd3;
      mdl_bytes[0] = 8'h11; mdl_bytes[1] = 8'h22; mdl_bytes[2] = 8'h33; mdl_bytes[3] = 8'h44;
      issue(25'h0000100);
      while (!req_ready) @(negedge clk);
      issue(25'h1000200);
      for (int i = 0; i < 20 && !(qspi_cs_n != 2'b11); i++) @(negedge clk);
      check("R8", "deselect gap at least one period", (last_gap >= 16) ? 1 : 0, 1);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic t_disabled();
      logic [1:0] cs_acc;
      cs_acc = '0;
      cfg_enable = 1'b0;
      @(negedge clk);
      req_addr = 25'h0ABCDE;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9", "immediate response", rsp_valid, 1);
      check("R9", "error flag", rsp_err, 1);
      check("R9", "zero data", rsp_data, 0);
      for (int i = 0; i < 40; i++) begin
         cs_acc = cs_acc | ~qspi_cs_n;
         @(negedge clk);
      end
      check("R9", "no chip select", cs_acc, 2'b00);
      cfg_enable = 1'b1;
   endtask

   task automatic t_abort();
      model_clear();
      cfg_div = 3'd2;
      issue(25'h0123456);
      for (int i = 0; i < 60; i++) @(negedge clk);
      check("R10", "transfer in progress", qspi_cs_n, 2'b10);
      cfg_enable = 1'b0;
      @(negedge clk);
      check("R10", "chip selects high", qspi_cs_n, 2'b11);
      check("R10", "abort response", rsp_valid, 1);
      check("R10", "abort error", rsp_err, 1);
      check("R10", "abort zero data", rsp_data, 0);
      cfg_enable = 1'b1;
      while (!req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      cfg_enable = 1'b1;
      do_read(25'h0012345, 3'd2, 8,   8'hA1, 8'hB2, 8'hC3, 8'hD4);
      do_read(25'h1ABCDEF, 3'd3, 16,  8'h5A, 8'h0F, 8'hF0, 8'h96);
      do_read(25'h0FFFFFF, 3'd0, 8,   8'h01, 8'h80, 8'h7E, 8'hE7);
      do_read(25'h1000000, 3'd7, 256, 8'hDE, 8'hAD, 8'hBE, 8'hEF);
      t_back_to_back();
      t_disabled();
      t_abort();
      do_read(25'h0A5A5A5, 3'd4, 32,  8'h12, 8'h34, 8'h56, 8'h78);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule